// File: doc/BRIEF.md
# Color Palette Host Access Controller

This block gives a host processor access to a color lookup table. The table has a 256-entry main region and a three-entry overlay region. Each entry is 30 bits: a 10-bit red, green and blue component. The host sees the table through a narrow bus. It loads an address first. It then moves one color component per access, in red, green, blue order. The block stages the red and green components of a write. It writes the whole entry to storage only when the blue component arrives. After every blue access, read or write, the address steps to the next entry.

The bus runs in one of two widths. In 10-bit mode, one access carries a whole address or a whole component. In 8-bit mode, the address is loaded in two byte writes. A full-precision component then takes two accesses: the upper eight bits first, then the two lowest bits. An 8-bit precision mode also exists. In that mode each component is a single byte, and every entry effectively holds 24 bits of color.

Top module: `cpal_host_ctrl`

## Requirements
- R1: After reset the address register is 000H, the component pointer is at red, no address byte is pending, and bus_rdata is zero.
- R2: A read with bus_sel=00 returns the address register without changing any state. It returns bits 9–0 on a 10-bit bus and bits 7–0 on an 8-bit bus. A write with bus_sel=00 on a 10-bit bus loads bus_wdata[9:0] zero-extended to 11 bits.
- R3: On an 8-bit bus, address writes alternate between two targets. The first write of a pair loads bus_wdata[7:0] into address bits 7–0. The second loads bus_wdata[2:0] into address bits 10–8.
- R4: Palette accesses (bus_sel=01) step the pointer red, green, blue, then back to red. Any address write returns the pointer, and the sub-byte phase, to red.
- R5: On palette writes, red and green are only staged. The blue write stores {red[29:20], green[19:10], blue[9:0]} at the current address. A write sequence cut short by an address write leaves the entry unchanged.
- R6: Each completed blue access, read or write, advances the address. Red and green accesses never change it. Outside the two wrap points below, the address goes up by one, modulo 2^11.
- R7: A blue access at 0FFH sets the address to 000H.
- R8: The overlay occupies 101H–103H, separate from the main entries. A blue access at 103H sets the address back to 101H.
- R9: With an 8-bit bus and 10-bit components, each component takes two accesses. The first carries bits 9–2 in data[7:0]. The second carries bits 1–0 in data[1:0], with the other read bits zero.
- R10: In 8-bit component mode, each component takes one access on either bus width. A write stores data[7:0] as component bits 9–2 with bits 1–0 cleared. A read returns component bits 9–2 in data[7:0].
- R11: At unmapped addresses (100H and 104H upward), palette writes are dropped and palette reads return zero. The pointer and the address increment behave as usual.
- R12: Accesses with bus_sel[1]=1 change no state, and reads with those selects return zero.
- R13: A read updates bus_rdata on the clock edge that samples the strobe. bus_rdata holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_sel | input | 2 | Target select: 00 address, 01 palette data, 1x no target |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Registered read data |
| cfg_bus8 | input | 1 | 1 = 8-bit bus mode |
| cfg_comp8 | input | 1 | 1 = 8-bit component precision |

## Verification
The two wrap points need the address register to sit on the last entry of a region exactly when a blue access completes. Only a complete three-component sequence reaches that point. The stimulus therefore loads 0FFH and 103H directly and runs full write sequences through them. It also crosses from the unmapped 100H into the overlay. In the mixed-width case, the sub-byte phase and the component pointer have to agree. To show this, entries are written in one bus mode and read back in the other, so each split access must land in the right bit positions.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
  localparam int CP_COMP_W      = 10;
  localparam int CP_BYTE_W      = 8;
  localparam int CP_ADDR_W      = 11;
  localparam int CP_MAIN_DEPTH  = 256;
  localparam int CP_OVL_DEPTH   = 3;
  localparam int CP_WORD_W      = 3 * CP_COMP_W;
  localparam int CP_LO_W        = CP_COMP_W - CP_BYTE_W;
  localparam int CP_HI_W        = CP_ADDR_W - CP_BYTE_W;
  localparam int CP_OVL_BASE    = CP_MAIN_DEPTH + 1;
  localparam int CP_OVL_LAST    = CP_OVL_BASE + CP_OVL_DEPTH - 1;
  localparam int CP_STORE_DEPTH = CP_MAIN_DEPTH + CP_OVL_DEPTH;
  localparam int CP_IDX_W       = $clog2(CP_STORE_DEPTH);

  typedef logic [CP_ADDR_W-1:0] paddr_t;
  typedef logic [CP_COMP_W-1:0] comp_t;
  typedef logic [CP_WORD_W-1:0] word_t;
  typedef logic [CP_IDX_W-1:0]  idx_t;
  typedef enum logic [1:0] {CH_RED = 2'd0, CH_GRN = 2'd1, CH_BLU = 2'd2} chan_e;

  function automatic logic is_main(paddr_t a);
    return a < paddr_t'(CP_MAIN_DEPTH);
  endfunction

  function automatic logic is_ovl(paddr_t a);
    return (a >= paddr_t'(CP_OVL_BASE)) && (a <= paddr_t'(CP_OVL_LAST));
  endfunction

  // step after a blue access: main and overlay regions wrap on themselves
  function automatic paddr_t next_addr(paddr_t a);
    if (a == paddr_t'(CP_MAIN_DEPTH - 1)) return '0;
    if (a == paddr_t'(CP_OVL_LAST))       return paddr_t'(CP_OVL_BASE);
    return a + paddr_t'(1);
  endfunction

  // storage row: overlay rows follow the main rows without a gap
  function automatic idx_t store_idx(paddr_t a);
    if (is_main(a)) return idx_t'(a);
    if (is_ovl(a))  return idx_t'(a - paddr_t'(CP_OVL_BASE - CP_MAIN_DEPTH));
    return '0;
  endfunction

  function automatic comp_t comp_of(word_t w, chan_e c);
    case (c)
      CH_RED:  return w[2*CP_COMP_W +: CP_COMP_W];
      CH_GRN:  return w[CP_COMP_W +: CP_COMP_W];
      default: return w[0 +: CP_COMP_W];
    endcase
  endfunction
endpackage

// File: rtl/cpal_addr_reg.sv
module cpal_addr_reg
  import cpal_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           addr_wr,
  input  logic           bus8,
  input  comp_t          wdata,
  input  logic           step,
  output paddr_t         addr
);
  logic hi_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      hi_pend <= 1'b0;
    end else if (addr_wr) begin
      if (bus8) begin
        if (!hi_pend) addr[CP_BYTE_W-1:0] <= wdata[CP_BYTE_W-1:0];
        else          addr[CP_ADDR_W-1:CP_BYTE_W] <= wdata[CP_HI_W-1:0];
        hi_pend <= ~hi_pend;
      end else begin
        addr <= paddr_t'(wdata);
      end
    end else if (step) begin
      addr <= next_addr(addr);
    end
  end
endmodule

// File: rtl/cpal_store.sv
module cpal_store
  import cpal_pkg::*;
(
  input  logic  clk,
  input  logic  we,
  input  idx_t  idx,
  input  word_t wword,
  output word_t rword
);
  word_t mem [CP_STORE_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wword;
  end

  assign rword = mem[idx];
endmodule

// File: rtl/cpal_seq.sv
module cpal_seq
  import cpal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pal_acc,
  input  logic  rw,
  input  logic  bus8,
  input  logic  comp8,
  input  comp_t wdata,
  input  logic  addr_wr,
  input  logic  mapped,
  input  word_t ram_rword,
  output logic  ram_we,
  output word_t ram_wword,
  output logic  blue_done,
  output logic  latch_ld,
  output comp_t rd_val,
  output chan_e ptr,
  output logic  sub
);
  logic                 split;
  logic                 first;
  logic                 comp_done;
  word_t                snap, snap_src;
  comp_t                rd_comp, wr_comp;
  logic [CP_BYTE_W-1:0] hi_stage;
  comp_t                stg [2];

  assign split     = bus8 & ~comp8;
  assign first     = (ptr == CH_RED) && !sub;
  assign comp_done = pal_acc && (!split || sub);
  assign blue_done = comp_done && (ptr == CH_BLU);
  assign latch_ld  = pal_acc && rw && first;
  assign snap_src  = first ? (mapped ? ram_rword : '0) : snap;
  assign rd_comp   = comp_of(snap_src, ptr);
  assign ram_we    = blue_done && !rw && mapped;
  assign ram_wword = {stg[0], stg[1], wr_comp};

  always_comb begin
    if (comp8)      rd_val = {{CP_LO_W{1'b0}}, rd_comp[CP_COMP_W-1:CP_LO_W]};
    else if (!split) rd_val = rd_comp;
    else if (!sub)  rd_val = {{CP_LO_W{1'b0}}, rd_comp[CP_COMP_W-1:CP_LO_W]};
    else            rd_val = {{CP_BYTE_W{1'b0}}, rd_comp[CP_LO_W-1:0]};
  end

  always_comb begin
    if (comp8)      wr_comp = {wdata[CP_BYTE_W-1:0], {CP_LO_W{1'b0}}};
    else if (split) wr_comp = {hi_stage, wdata[CP_LO_W-1:0]};
    else            wr_comp = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= CH_RED;
      sub      <= 1'b0;
      snap     <= '0;
      hi_stage <= '0;
    end else if (addr_wr) begin
      ptr <= CH_RED;
      sub <= 1'b0;
    end else if (pal_acc) begin
      if (latch_ld) snap <= snap_src;
      if (split && !sub) begin
        sub <= 1'b1;
        if (!rw) hi_stage <= wdata[CP_BYTE_W-1:0];
      end else begin
        sub <= 1'b0;
        ptr <= (ptr == CH_BLU) ? CH_RED : chan_e'(ptr + 2'd1);
      end
    end
  end

  // red and green staging rows
  for (genvar g = 0; g < 2; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= '0;
      else if (comp_done && !rw && (ptr == chan_e'(g))) stg[g] <= wr_comp;
    end
  end
endmodule

// File: rtl/cpal_host_ctrl.sv
module cpal_host_ctrl
  import cpal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_stb,
  input  logic                 bus_rw,
  input  logic [1:0]           bus_sel,
  input  logic [CP_COMP_W-1:0] bus_wdata,
  output logic [CP_COMP_W-1:0] bus_rdata,
  input  logic                 cfg_bus8,
  input  logic                 cfg_comp8
);
  logic   addr_wr, addr_rd, pal_acc, null_rd;
  logic   mapped, ram_we, blue_done, latch_ld, sub;
  paddr_t addr;
  chan_e  ptr;
  word_t  ram_rword, ram_wword;
  comp_t  pal_rd, addr_view;

  assign addr_wr = bus_stb && !bus_rw && (bus_sel == 2'b00);
  assign addr_rd = bus_stb &&  bus_rw && (bus_sel == 2'b00);
  assign pal_acc = bus_stb && (bus_sel == 2'b01);
  assign null_rd = bus_stb &&  bus_rw && bus_sel[1];
  assign mapped  = is_main(addr) || is_ovl(addr);
  assign addr_view = cfg_bus8 ? {{CP_LO_W{1'b0}}, addr[CP_BYTE_W-1:0]} : addr[CP_COMP_W-1:0];

  cpal_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .bus8(cfg_bus8),
    .wdata(bus_wdata), .step(blue_done), .addr(addr)
  );

  cpal_store u_store (
    .clk(clk), .we(ram_we), .idx(store_idx(addr)), .wword(ram_wword), .rword(ram_rword)
  );

  cpal_seq u_seq (
    .clk(clk), .rst_n(rst_n), .pal_acc(pal_acc), .rw(bus_rw), .bus8(cfg_bus8),
    .comp8(cfg_comp8), .wdata(bus_wdata), .addr_wr(addr_wr), .mapped(mapped),
    .ram_rword(ram_rword), .ram_we(ram_we), .ram_wword(ram_wword),
    .blue_done(blue_done), .latch_ld(latch_ld), .rd_val(pal_rd), .ptr(ptr), .sub(sub)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (pal_acc && bus_rw) bus_rdata <= pal_rd;
    else if (addr_rd)          bus_rdata <= addr_view;
    else if (null_rd)          bus_rdata <= '0;
  end
endmodule

// File: rtl/cpal_host_ctrl_chk.sv
module cpal_host_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] addr,
  input logic [1:0]  ptr,
  input logic        sub,
  input logic        blue_done,
  input logic        addr_wr,
  input logic        pal_acc,
  input logic        ram_we,
  input logic        bus_stb,
  input logic        bus_rw,
  input logic [1:0]  bus_sel,
  input logic [9:0]  bus_rdata
);
  // R7
  wrap_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blue_done && addr == 11'h0FF |=> addr == 11'h000);

  // R8
  wrap_ovl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blue_done && addr == 11'h103 |=> addr == 11'h101);

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blue_done && addr != 11'h0FF && addr != 11'h103 |=> addr == $past(addr) + 11'd1);

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_acc && !blue_done |=> $stable(addr));

  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ptr == 2'd0 && !sub);

  // R5
  commit_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ptr == 2'd0);

  // R12
  null_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb && bus_sel[1] |=> $stable(addr) && $stable(ptr) && $stable(sub));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_stb && bus_rw) |=> $stable(bus_rdata));
endmodule

bind cpal_host_ctrl cpal_host_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ptr(ptr), .sub(sub),
  .blue_done(blue_done), .addr_wr(addr_wr), .pal_acc(pal_acc), .ram_we(ram_we),
  .bus_stb(bus_stb), .bus_rw(bus_rw), .bus_sel(bus_sel), .bus_rdata(bus_rdata)
);

// File: tb/cpal_host_ctrl_tb.sv
module cpal_host_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_stb = 1'b0, bus_rw = 1'b0;
  logic [1:0] bus_sel = 2'b00;
  logic [9:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  logic       cfg_bus8 = 1'b0, cfg_comp8 = 1'b0;

  int checks = 0, failures = 0;
  logic done = 1'b0;

  // reference model state
  int m_addr = 0, m_ptr = 0, m_sub = 0, m_ahi = 0, m_hi = 0, m_snap = 0, m_exp = 0;
  int m_stg [3];
  int m_mem [int];

  always #10 clk = ~clk;

  cpal_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_rw(bus_rw), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_bus8(cfg_bus8), .cfg_comp8(cfg_comp8)
  );

  function automatic int m_mapped(int a);
    return (a < 256 || (a >= 257 && a <= 259)) ? 1 : 0;
  endfunction

  function automatic int m_next(int a);
    if (a == 255) return 0;
    if (a == 259) return 257;
    return (a + 1) & 'h7FF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic [1:0] s, logic rw, int d);
    int two, c, v;
    if (s == 2'b00) begin
      if (!rw) begin
        if (cfg_bus8) begin
          if (m_ahi == 0) begin m_addr = (m_addr & 'h700) | (d & 'hFF); m_ahi = 1; end
          else begin m_addr = (m_addr & 'hFF) | ((d & 7) << 8); m_ahi = 0; end
        end else m_addr = d & 'h3FF;
        m_ptr = 0; m_sub = 0;
      end else m_exp = cfg_bus8 ? (m_addr & 'hFF) : (m_addr & 'h3FF);
    end else if (s == 2'b01) begin
      two = (cfg_bus8 && !cfg_comp8) ? 1 : 0;
      if (rw && m_ptr == 0 && m_sub == 0)
        m_snap = (m_mapped(m_addr) != 0 && m_mem.exists(m_addr)) ? m_mem[m_addr] : 0;
      if (rw) begin
        c = (m_snap >> (20 - 10 * m_ptr)) & 'h3FF;
        if (cfg_comp8) m_exp = c >> 2;
        else if (two != 0) m_exp = (m_sub != 0) ? (c & 3) : (c >> 2);
        else m_exp = c;
      end
      if (two != 0 && m_sub == 0) begin
        m_sub = 1; m_hi = d & 'hFF;
      end else begin
        m_sub = 0;
        if (cfg_comp8) v = (d & 'hFF) << 2;
        else if (two != 0) v = (m_hi << 2) | (d & 3);
        else v = d & 'h3FF;
        if (!rw) m_stg[m_ptr] = v;
        if (m_ptr == 2) begin
          if (!rw && m_mapped(m_addr) != 0)
            m_mem[m_addr] = (m_stg[0] << 20) | (m_stg[1] << 10) | m_stg[2];
          m_addr = m_next(m_addr); m_ptr = 0;
        end else m_ptr++;
      end
    end else if (rw) m_exp = 0;
  endtask

  // every-clock comparison against the model (R13 and all read paths)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== m_exp[9:0]) begin
        failures++;
        $display("FAIL R13 model actual=%0h expected=%0h", bus_rdata, m_exp[9:0]);
      end
    end
  end

  task automatic acc(logic [1:0] s, logic rw, int d);
    bus_stb = 1'b1; bus_sel = s; bus_rw = rw; bus_wdata = d[9:0];
    @(posedge clk);
    #1 model_step(s, rw, d);
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output int v);
    acc(s, 1'b1, 0);
    v = int'(bus_rdata);
  endtask

  task automatic wr_entry(int r, int g, int b);
    acc(2'b01, 1'b0, r); acc(2'b01, 1'b0, g); acc(2'b01, 1'b0, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata reset", int'(bus_rdata), 0);
    rd(2'b00, v); chk("R1 addr reset", v, 0);

    // R2 / R5 / R6 basic write and readback
    acc(2'b00, 1'b0, 5);
    wr_entry('h3A5, 'h155, 'h2AA);
    rd(2'b00, v); chk("R6 addr after blue write", v, 6);
    acc(2'b00, 1'b0, 5);
    rd(2'b01, v); chk("R5 red", v, 'h3A5);
    rd(2'b01, v); chk("R4 green", v, 'h155);
    rd(2'b01, v); chk("R4 blue", v, 'h2AA);
    rd(2'b00, v); chk("R6 addr after blue read", v, 6);

    // R5 partial write aborted
    acc(2'b00, 1'b0, 5);
    acc(2'b01, 1'b0, 'h111); acc(2'b01, 1'b0, 'h222);
    acc(2'b00, 1'b0, 5);
    rd(2'b01, v); chk("R5 partial write no effect", v, 'h3A5);

    // R4 pointer reset by address write
    acc(2'b00, 1'b0, 7);
    wr_entry(1, 2, 3);
    acc(2'b00, 1'b0, 7);
    rd(2'b01, v); chk("R4 red first", v, 1);
    acc(2'b00, 1'b0, 7);
    rd(2'b01, v); chk("R4 red after reload", v, 1);
    rd(2'b01, v); chk("R4 green after reload", v, 2);

    // R7 main wrap
    acc(2'b00, 1'b0, 1);
    wr_entry('h001, 'h002, 'h003);
    acc(2'b00, 1'b0, 'hFF);
    wr_entry('h0AA, 'h0BB, 'h0CC);
    rd(2'b00, v); chk("R7 wrap to 000", v, 0);

    // R8 overlay
    acc(2'b00, 1'b0, 'h101);
    wr_entry('h010, 'h020, 'h030);
    wr_entry('h011, 'h021, 'h031);
    rd(2'b00, v); chk("R8 overlay step", v, 'h103);
    wr_entry('h012, 'h022, 'h032);
    rd(2'b00, v); chk("R8 overlay wrap", v, 'h101);
    rd(2'b01, v); chk("R8 overlay red", v, 'h010);
    acc(2'b00, 1'b0, 1);
    rd(2'b01, v); chk("R8 main separate", v, 'h001);

    // R11 unmapped
    acc(2'b00, 1'b0, 'h100);
    wr_entry(7, 7, 7);
    rd(2'b00, v); chk("R11 step from 100", v, 'h101);
    rd(2'b01, v); chk("R11 overlay untouched", v, 'h010);
    acc(2'b00, 1'b0, 'h100);
    rd(2'b01, v); chk("R11 unmapped read zero", v, 0);

    // R12 null selects
    acc(2'b00, 1'b0, 5);
    rd(2'b01, v); chk("R12 red before", v, 'h3A5);
    acc(2'b10, 1'b0, 'h3FF);
    rd(2'b11, v); chk("R12 null read zero", v, 0);
    rd(2'b01, v); chk("R12 pointer kept", v, 'h155);

    // R13 hold across a write
    rd(2'b01, v);
    acc(2'b00, 1'b0, 9);
    chk("R13 hold", int'(bus_rdata), 'h2AA);

    // R3 / R9 8-bit bus, 10-bit components
    cfg_bus8 = 1'b1;
    acc(2'b00, 1'b0, 'h20); acc(2'b00, 1'b0, 0);
    rd(2'b00, v); chk("R3 low byte", v, 'h20);
    acc(2'b01, 1'b0, 'h71); acc(2'b01, 1'b0, 3);
    acc(2'b01, 1'b0, 'h3C); acc(2'b01, 1'b0, 0);
    acc(2'b01, 1'b0, 'hCA); acc(2'b01, 1'b0, 3);
    rd(2'b00, v); chk("R9 addr after six accesses", v, 'h21);
    acc(2'b00, 1'b0, 'h20); acc(2'b00, 1'b0, 0);
    rd(2'b01, v); chk("R9 red high", v, 'h71);
    rd(2'b01, v); chk("R9 red low", v, 3);
    rd(2'b01, v); chk("R9 green high", v, 'h3C);
    acc(2'b00, 1'b0, 'h02); acc(2'b00, 1'b0, 'h01);
    cfg_bus8 = 1'b0;
    rd(2'b00, v); chk("R3 high byte", v, 'h102);
    acc(2'b00, 1'b0, 'h20);
    rd(2'b01, v); chk("R9 red full", v, 'h1C7);
    rd(2'b01, v); chk("R9 green full", v, 'h0F0);
    rd(2'b01, v); chk("R9 blue full", v, 'h32B);

    // R10 8-bit components
    cfg_comp8 = 1'b1;
    acc(2'b00, 1'b0, 9);
    wr_entry('h3AB, 'h1CD, 'h0EF);
    cfg_comp8 = 1'b0;
    acc(2'b00, 1'b0, 9);
    rd(2'b01, v); chk("R10 red stored", v, 'h2AC);
    rd(2'b01, v); chk("R10 green stored", v, 'h334);
    rd(2'b01, v); chk("R10 blue stored", v, 'h3BC);
    cfg_comp8 = 1'b1;
    acc(2'b00, 1'b0, 9);
    rd(2'b01, v); chk("R10 red byte read", v, 'hAB);
    cfg_bus8 = 1'b1;
    acc(2'b00, 1'b0, 'h0A); acc(2'b00, 1'b0, 0);
    wr_entry('h12, 'h34, 'h56);
    rd(2'b00, v); chk("R10 one access per component", v, 'h0B);
    cfg_bus8 = 1'b0; cfg_comp8 = 1'b0;
    acc(2'b00, 1'b0, 'h0A);
    rd(2'b01, v); chk("R10 byte bus red", v, 'h048);
    rd(2'b01, v); chk("R10 byte bus green", v, 'h0D0);

    // R2 address readback has no side effect
    rd(2'b00, v);
    rd(2'b01, v); chk("R2 readback no side effect", v, 'h158);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule